// File: doc/BRIEF.md
# I2C Slave Address Window Matcher

This block decides whether the address phase of an I2C transfer selects this slave. A shift register outside the block collects each received byte and raises a one-cycle strobe when the byte is complete. A second flag marks the byte that directly follows a START. The matcher compares that byte against a programmed primary address. It can also accept any address inside a programmable window above the primary address. When the block is selected, it returns a one-cycle match pulse together with the read/write direction bit of the transfer.

The window is bounded by the primary address at the bottom and by a separate upper-bound address at the top. The bottom bound is excluded and the top bound is included. A run-time enable switches the window on or off. When 10-bit addressing is enabled, a 3-bit field supplies the three most significant bits of a 10-bit slave address, and the primary address supplies the low seven bits. The first byte must then carry the reserved 10-bit prefix, and a match is declared only after the second byte has also been compared.

Top module: `i2c_addr_window_match`

## Requirements
- R1: With 10-bit mode off, a first-byte strobe whose bits 7:1 equal `own_addr` gives `match`=1, and `rw_dir` then equals bit 0 of that byte. A strobe with `addr_first`=0 never matches in this mode.
- R2: With 10-bit mode off and `range_en`=1, a first byte whose bits 7:1 are strictly greater than `own_addr` and less than or equal to `range_top` matches. Values equal to `range_top`+1 or lower than `own_addr` do not match.
- R3: With `range_en`=0, only the exact `own_addr` matches. Every other value inside the window gives no match.
- R4: When `range_top` is less than or equal to `own_addr`, enabling the window matches nothing except the exact address.
- R5: `match` rises on the first clock edge after the strobe and stays high for exactly one cycle. If no further strobe arrives, it is low on the following cycle.
- R6: With 10-bit mode on, the 10-bit address is {`ten_hi`, `own_addr`}. The first byte must be 11110 in bits 7:3, with bits 2:1 equal to `ten_hi`[2:1]. That byte alone gives no match. A following strobe with `addr_first`=0 whose byte equals {`ten_hi`[0], `own_addr`} then matches, and `rw_dir` carries bit 0 of the first byte.
- R7: In 10-bit mode, a wrong prefix, wrong upper bits, or a wrong second byte gives no match.
- R8: With 10-bit mode off, `ten_hi` has no effect on matching.
- R9: With 10-bit mode on, a 7-bit style first byte equal to `own_addr` shifted left does not match.
- R10: A synchronous `rst` clears `match` and `rw_dir` and abandons a pending 10-bit sequence, so a second byte that follows a reset does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| own_addr | input | 7 | Primary slave address (low seven bits in 10-bit mode) |
| range_top | input | 7 | Inclusive upper bound of the address window |
| range_en | input | 1 | Enables window matching |
| ten_bit_en | input | 1 | Selects 10-bit addressing |
| ten_hi | input | 3 | Upper three bits of the 10-bit address |
| rx_byte | input | 8 | Completed received byte |
| byte_strobe | input | 1 | One-cycle pulse: `rx_byte` is complete |
| addr_first | input | 1 | Qualifies the strobe as the first byte after START |
| match | output | 1 | One-cycle pulse: this slave is addressed |
| rw_dir | output | 1 | Direction bit of the matched transfer |

## Verification
Every result comes from a single register stage. `match` and `rw_dir` change on the clock edge that samples the strobe, so they are due one cycle after the strobe is driven. The bench drives each strobe on a falling edge and reads `match` and `rw_dir` on the next falling edge. It checks one cycle later that the pulse has ended. For a 10-bit address, the first byte is checked for no match before the second byte is sent. The final decision is due one cycle after the second strobe.

// File: rtl/i2cwm_pkg.sv
package i2cwm_pkg;
    localparam int ADDR7_W  = 7;
    localparam int HI_W     = 3;
    localparam int BYTE_W   = ADDR7_W + 1;
    localparam int PREFIX_W = BYTE_W - 3;
    localparam logic [PREFIX_W-1:0] TEN_PREFIX = 5'b11110;

    typedef struct packed {
        logic hit;
        logic dir;
        logic pend;
        logic pend_dir;
    } mstate_t;
endpackage

// File: rtl/i2cwm_cmp7.sv
module i2cwm_cmp7 #(
    parameter int W = 7
) (
    input  logic [W-1:0] cand,
    input  logic [W-1:0] base,
    input  logic [W-1:0] top,
    input  logic         win_en,
    output logic         exact_hit,
    output logic         window_hit
);
    logic above_base;
    logic under_top;

    always_comb begin
        exact_hit  = (cand == base);
        above_base = (cand > base);
        under_top  = (cand <= top);
        window_hit = win_en && above_base && under_top;
    end
endmodule

// File: rtl/i2cwm_ten.sv
module i2cwm_ten
    import i2cwm_pkg::*;
#(
    parameter int LOW_W = ADDR7_W,
    parameter int HW    = HI_W
) (
    input  logic [LOW_W:0]   head_byte,
    input  logic [LOW_W:0]   tail_byte,
    input  logic [LOW_W-1:0] low_addr,
    input  logic [HW-1:0]    hi_addr,
    output logic             head_ok,
    output logic             tail_ok
);
    localparam int PW = LOW_W + 1 - 3;

    logic prefix_ok;
    logic upper_ok;

    always_comb begin
        prefix_ok = (head_byte[LOW_W:3] == TEN_PREFIX[PW-1:0]);
        upper_ok  = (head_byte[2:1] == hi_addr[HW-1:HW-2]);
        head_ok   = prefix_ok && upper_ok;
        tail_ok   = (tail_byte == {hi_addr[0], low_addr});
    end
endmodule

// File: rtl/i2c_addr_window_match.sv
module i2c_addr_window_match
    import i2cwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR7_W-1:0] own_addr,
    input  logic [ADDR7_W-1:0] range_top,
    input  logic               range_en,
    input  logic               ten_bit_en,
    input  logic [HI_W-1:0]    ten_hi,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               byte_strobe,
    input  logic               addr_first,
    output logic               match,
    output logic               rw_dir
);
    mstate_t st_d, st_q;
    logic    exact_hit, window_hit, head_ok, tail_ok;

    i2cwm_cmp7 #(.W(ADDR7_W)) u_cmp7 (
        .cand      (rx_byte[BYTE_W-1:1]),
        .base      (own_addr),
        .top       (range_top),
        .win_en    (range_en),
        .exact_hit (exact_hit),
        .window_hit(window_hit)
    );

    i2cwm_ten #(.LOW_W(ADDR7_W), .HW(HI_W)) u_ten (
        .head_byte(rx_byte),
        .tail_byte(rx_byte),
        .low_addr (own_addr),
        .hi_addr  (ten_hi),
        .head_ok  (head_ok),
        .tail_ok  (tail_ok)
    );

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        if (byte_strobe) begin
            st_d.pend = 1'b0;
            if (addr_first) begin
                if (!ten_bit_en) begin
                    if (exact_hit || window_hit) begin
                        st_d.hit = 1'b1;
                        st_d.dir = rx_byte[0];
                    end
                end else if (head_ok) begin
                    st_d.pend     = 1'b1;
                    st_d.pend_dir = rx_byte[0];
                end
            end else if (ten_bit_en && st_q.pend && tail_ok) begin
                st_d.hit = 1'b1;
                st_d.dir = st_q.pend_dir;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match  = st_q.hit;
    assign rw_dir = st_q.dir;
endmodule

// File: rtl/i2cwm_chk.sv
module i2cwm_chk
    import i2cwm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ADDR7_W-1:0] own_addr,
    input logic [ADDR7_W-1:0] range_top,
    input logic               range_en,
    input logic               ten_bit_en,
    input logic [HI_W-1:0]    ten_hi,
    input logic [BYTE_W-1:0]  rx_byte,
    input logic               byte_strobe,
    input logic               addr_first,
    input logic               match,
    input logic               rw_dir
);
    logic seven_first;
    assign seven_first = byte_strobe && addr_first && !ten_bit_en;

    assert_exact_R1: assert property (@(posedge clk) disable iff (rst)
        (seven_first && rx_byte[BYTE_W-1:1] == own_addr) |=> (match && rw_dir == $past(rx_byte[0])));

    assert_window_R2: assert property (@(posedge clk) disable iff (rst)
        (seven_first && range_en && rx_byte[BYTE_W-1:1] > own_addr && rx_byte[BYTE_W-1:1] <= range_top) |=> match);

    assert_off_R3: assert property (@(posedge clk) disable iff (rst)
        (seven_first && !range_en && rx_byte[BYTE_W-1:1] != own_addr) |=> !match);

    assert_pulse_src_R5: assert property (@(posedge clk) disable iff (rst)
        match |-> $past(byte_strobe));

    assert_ten_head_R6: assert property (@(posedge clk) disable iff (rst)
        (byte_strobe && addr_first && ten_bit_en) |=> !match);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!match && !rw_dir));
endmodule

bind i2c_addr_window_match i2cwm_chk u_chk (.*);

// File: tb/i2c_addr_window_match_test.sv
module i2c_addr_window_match_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic [6:0] range_top = 7'h30;
    logic       range_en = 1'b0;
    logic       ten_bit_en = 1'b0;
    logic [2:0] ten_hi = 3'b101;
    logic [7:0] rx_byte = 8'h00;
    logic       byte_strobe = 1'b0;
    logic       addr_first = 1'b0;
    logic       match, rw_dir;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    i2c_addr_window_match uut (.*);

    task automatic chk(input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // drive one strobe, check result one cycle later, then check pulse has ended
    task automatic send(input logic [7:0] b, input bit first, input bit exp_m, input string tag);
        @(negedge clk);
        rx_byte = b; addr_first = first; byte_strobe = 1'b1;
        @(negedge clk);
        byte_strobe = 1'b0; addr_first = 1'b0;
        chk(match, exp_m, tag);
        @(negedge clk);
        chk(match, 1'b0, {tag, " R5 pulse end"});
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset;
        chk(match, 1'b0, "R10 match after reset");
        chk(rw_dir, 1'b0, "R10 dir after reset");
    endtask

    task automatic t_exact;
        range_en = 1'b0; ten_bit_en = 1'b0;
        send({7'h2A, 1'b1}, 1'b1, 1'b1, "R1 exact read");
        chk(rw_dir, 1'b1, "R1 dir read");
        send({7'h2A, 1'b0}, 1'b1, 1'b1, "R1 exact write");
        chk(rw_dir, 1'b0, "R1 dir write");
        send({7'h2A, 1'b0}, 1'b0, 1'b0, "R1 non-first strobe");
    endtask

    task automatic t_window;
        range_en = 1'b1; range_top = 7'h30;
        send({7'h2B, 1'b0}, 1'b1, 1'b1, "R2 base+1");
        send({7'h30, 1'b1}, 1'b1, 1'b1, "R2 top inclusive");
        chk(rw_dir, 1'b1, "R2 dir");
        send({7'h31, 1'b0}, 1'b1, 1'b0, "R2 top+1");
        send({7'h29, 1'b0}, 1'b1, 1'b0, "R2 below base");
        send({7'h2A, 1'b0}, 1'b1, 1'b1, "R2 exact in range mode");
    endtask

    task automatic t_range_off;
        range_en = 1'b0; range_top = 7'h30;
        send({7'h2B, 1'b0}, 1'b1, 1'b0, "R3 base+1 off");
        send({7'h30, 1'b0}, 1'b1, 1'b0, "R3 top off");
    endtask

    task automatic t_inverted;
        range_en = 1'b1; range_top = 7'h20;
        send({7'h2B, 1'b0}, 1'b1, 1'b0, "R4 above base low top");
        send({7'h21, 1'b0}, 1'b1, 1'b0, "R4 between top and base");
        send({7'h2A, 1'b0}, 1'b1, 1'b1, "R4 exact");
        range_top = 7'h2A;
        send({7'h2B, 1'b0}, 1'b1, 1'b0, "R4 top equals base");
        range_en = 1'b0; range_top = 7'h30;
    endtask

    task automatic t_ten;
        ten_bit_en = 1'b1; ten_hi = 3'b101;
        send(8'hF5, 1'b1, 1'b0, "R6 head alone");
        send(8'hAA, 1'b0, 1'b1, "R6 tail match");
        chk(rw_dir, 1'b1, "R6 dir from head");
        send(8'hF4, 1'b1, 1'b0, "R6 head write");
        send(8'hAA, 1'b0, 1'b1, "R6 tail match write");
        chk(rw_dir, 1'b0, "R6 dir write");
    endtask

    task automatic t_ten_bad;
        ten_bit_en = 1'b1; ten_hi = 3'b101;
        send(8'hF4, 1'b1, 1'b0, "R7 head");
        send(8'hAB, 1'b0, 1'b0, "R7 wrong tail");
        send(8'hF6, 1'b1, 1'b0, "R7 wrong upper bits");
        send(8'hAA, 1'b0, 1'b0, "R7 tail after bad upper");
        send(8'hE4, 1'b1, 1'b0, "R7 bad prefix");
        send(8'hAA, 1'b0, 1'b0, "R7 tail after bad prefix");
    endtask

    task automatic t_ten_seven;
        ten_bit_en = 1'b1;
        send({7'h2A, 1'b0}, 1'b1, 1'b0, "R9 7-bit byte in 10-bit mode");
    endtask

    task automatic t_hi_ignored;
        ten_bit_en = 1'b0; range_en = 1'b0;
        ten_hi = 3'b010;
        send({7'h2A, 1'b0}, 1'b1, 1'b1, "R8 hi 010");
        ten_hi = 3'b111;
        send({7'h2A, 1'b1}, 1'b1, 1'b1, "R8 hi 111");
        send(8'hFE, 1'b1, 1'b0, "R8 prefix byte in 7-bit mode");
        ten_hi = 3'b101;
    endtask

    task automatic t_reset_abort;
        ten_bit_en = 1'b1; ten_hi = 3'b101;
        send(8'hF4, 1'b1, 1'b0, "R10 head");
        do_reset();
        send(8'hAA, 1'b0, 1'b0, "R10 tail after reset");
        ten_bit_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_exact();
        t_window();
        t_range_off();
        t_inverted();
        t_ten();
        t_ten_bad();
        t_ten_seven();
        t_hi_ignored();
        t_reset_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule